// File: doc/BRIEF.md
# Supply Switchover Monitor with Time Records

This block sits beside the calendar of a battery-backed timekeeper and keeps track of how the part is powered. Three digitised comparator results arrive from the analog side: one for the main supply and one for each of two battery thresholds. A presence flag tells the block whether the main supply is up. The block holds the trip codes that the analog comparators use. It raises sticky status flags when an enabled comparator reports a low level. It also stores the calendar time at supply switchovers.

Two records are kept. The first holds the time at which the part first left main power for the battery since the records were last cleared. The second holds the time of the most recent return to main power. Each record is taken in one clock from one calendar snapshot. A self-clearing control bit empties both records. A separate shipping bit keeps the battery disconnected until the main supply has gone down and come back. Software reaches all of this through a simple byte-wide register port: writes take effect on the clock edge and reads are combinational.

Top module: `pwr_ts_top`

## Requirements
- R1: The main control register at address 09h holds the main-supply trip code in bits 2:0. The code reads back unchanged and appears on `main_trip_code`. Bit 7 of this register always reads 0.
- R2: Main trip codes 0 to 5 assert `main_cmp_en`. While it is enabled and `main_below` is high, status bit 0 of address 00h becomes set. Codes 6 and 7 deassert `main_cmp_en`, and status bit 0 is then never set.
- R3: The battery control register at address 0Ah holds the first battery code in bits 5:3 and the second in bits 2:0. They drive `bat1_trip_code` and `bat2_trip_code`. Codes 0 to 6 enable the matching comparator, and code 7 disables it. An enabled low result sets status bit 1 (first threshold) or status bit 2 (second threshold).
- R4: A fall of `main_present` stores the calendar into the battery-entry record, read at 10h to 15h (seconds, minutes, hours, day, month, year). This happens only when that record is empty, and status bit 3 then reads 1. Later falls leave the record unchanged.
- R5: Every rise of `main_present` stores the calendar into the return record, read at 18h to 1Dh in the same field order, and sets status bit 4. Each later rise overwrites it.
- R6: Writing 09h with bit 7 set clears both records to zero and clears status bits 3 and 4. The bit is not stored. If a capture happens in the same cycle, the clear wins.
- R7: Bit 6 of 0Ah is the shipping bit. It drives `bat_disconnect` and reads back. It clears by itself at the next rise of `main_present`, which follows the supply going down.
- R8: Status flags in bits 2:0 are sticky. They stay set after the condition ends. Writing 0 to a flag bit clears it, and writing 1 has no effect. A new low result in the same cycle as a clear keeps the flag set.
- R9: Reserved bits are ignored on write and read as 0. These are bits 6:3 of 09h, bit 7 of 0Ah and bits 7:5 of 00h. Any unmapped address also reads 0.
- R10: All six fields of a record come from the calendar value present in the capture cycle. A calendar change in the next cycle does not alter the stored record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| main_present | input | 1 | Main supply is up |
| main_below | input | 1 | Main comparator reports the supply under its trip level |
| bat1_below | input | 1 | First battery comparator reports low |
| bat2_below | input | 1 | Second battery comparator reports low |
| cal_sec | input | 8 | Calendar seconds |
| cal_min | input | 8 | Calendar minutes |
| cal_hour | input | 8 | Calendar hours |
| cal_day | input | 8 | Calendar day of month |
| cal_mon | input | 8 | Calendar month |
| cal_year | input | 8 | Calendar year |
| main_trip_code | output | 3 | Trip code for the main comparator |
| main_cmp_en | output | 1 | Main comparator enabled |
| bat1_trip_code | output | 3 | Trip code for the first battery comparator |
| bat1_cmp_en | output | 1 | First battery comparator enabled |
| bat2_trip_code | output | 3 | Trip code for the second battery comparator |
| bat2_cmp_en | output | 1 | Second battery comparator enabled |
| bat_disconnect | output | 1 | Keep the battery isolated |

## Verification
The bench sweeps all eight main codes and all 64 pairs of battery codes, and drives the comparators low for each one. A design with an off-by-one boundary would enable a disabled code or silence a valid one, and so set or miss a status flag.

Repeated supply cycles check that the battery-entry record keeps the first time while the return record follows the latest one. A design that overwrote the wrong record, or that sampled the calendar one cycle late, would show the bench's junk follow-up value.

The bench also checks that the clear and shipping bits work as described and then return to 0. Writes to reserved bits and unmapped addresses must leave no trace in the read data.

// File: rtl/pwr_ts_pkg.sv
package pwr_ts_pkg;
    localparam int DW   = 8;
    localparam int NFLD = 6;
    localparam int SW   = DW * NFLD;
    localparam int NFLAG = 3;

    typedef logic [SW-1:0] stamp_t;
    typedef logic [2:0]    trip_t;

    localparam trip_t MAIN_TOP_CODE = 3'd5;
    localparam trip_t BAT_TOP_CODE  = 3'd6;

    localparam int FLG_MAIN = 0;
    localparam int FLG_BAT1 = 1;
    localparam int FLG_BAT2 = 2;

    localparam int ADR_STATUS = 0;
    localparam int ADR_MAIN   = 9;
    localparam int ADR_BAT    = 10;
    localparam int ADR_ENTRY  = 16;
    localparam int ADR_RETURN = 24;
endpackage

// File: rtl/pwr_ts_supply_edge.sv
module pwr_ts_supply_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic main_present,
    output logic to_battery,
    output logic to_main
);
    typedef struct packed {
        logic pres;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pres  = main_present;
        to_battery = st_q.pres & ~main_present;
        to_main    = ~st_q.pres & main_present;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pres: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pwr_ts_slot.sv
module pwr_ts_slot
    import pwr_ts_pkg::*;
#(
    parameter bit KEEP_FIRST = 1'b0
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   trig,
    input  logic   clr,
    input  stamp_t stamp_in,
    output logic   valid,
    output stamp_t stamp
);
    typedef struct packed {
        logic   valid;
        stamp_t stamp;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic     may_take;

    generate
        if (KEEP_FIRST) begin : g_first
            assign may_take = ~st_q.valid;
        end else begin : g_last
            assign may_take = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (trig && may_take) begin
            st_d.valid = 1'b1;
            st_d.stamp = stamp_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign stamp = st_q.stamp;
endmodule

// File: rtl/pwr_ts_ctrl.sv
module pwr_ts_ctrl
    import pwr_ts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_main,
    input  logic             wr_bat,
    input  logic             wr_stat,
    input  logic [DW-1:0]    wdata,
    input  logic             main_below,
    input  logic             bat1_below,
    input  logic             bat2_below,
    input  logic             to_main,
    output trip_t            main_sel,
    output trip_t            bat1_sel,
    output trip_t            bat2_sel,
    output logic             main_en,
    output logic             bat1_en,
    output logic             bat2_en,
    output logic [NFLAG-1:0] flags,
    output logic             reseal,
    output logic             clr_stamps
);
    typedef struct packed {
        trip_t            main_sel;
        trip_t            bat1_sel;
        trip_t            bat2_sel;
        logic             reseal;
        logic [NFLAG-1:0] flags;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    logic [NFLAG-1:0] raise;
    logic [NFLAG-1:0] keep;

    always_comb begin
        main_en = (st_q.main_sel <= MAIN_TOP_CODE);
        bat1_en = (st_q.bat1_sel <= BAT_TOP_CODE);
        bat2_en = (st_q.bat2_sel <= BAT_TOP_CODE);

        raise = '0;
        raise[FLG_MAIN] = main_en & main_below;
        raise[FLG_BAT1] = bat1_en & bat1_below;
        raise[FLG_BAT2] = bat2_en & bat2_below;
        keep = wr_stat ? wdata[NFLAG-1:0] : '1;

        st_d = st_q;
        if (wr_main) st_d.main_sel = wdata[2:0];
        if (wr_bat) begin
            st_d.bat1_sel = wdata[5:3];
            st_d.bat2_sel = wdata[2:0];
            st_d.reseal   = wdata[6];
        end
        if (to_main) st_d.reseal = 1'b0;
        st_d.flags = (st_q.flags & keep) | raise;

        clr_stamps = wr_main & wdata[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_sel = st_q.main_sel;
    assign bat1_sel = st_q.bat1_sel;
    assign bat2_sel = st_q.bat2_sel;
    assign flags    = st_q.flags;
    assign reseal   = st_q.reseal;
endmodule

// File: rtl/pwr_ts_top.sv
module pwr_ts_top
    import pwr_ts_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              main_present,
    input  logic              main_below,
    input  logic              bat1_below,
    input  logic              bat2_below,
    input  logic [7:0]        cal_sec,
    input  logic [7:0]        cal_min,
    input  logic [7:0]        cal_hour,
    input  logic [7:0]        cal_day,
    input  logic [7:0]        cal_mon,
    input  logic [7:0]        cal_year,
    output logic [2:0]        main_trip_code,
    output logic              main_cmp_en,
    output logic [2:0]        bat1_trip_code,
    output logic              bat1_cmp_en,
    output logic [2:0]        bat2_trip_code,
    output logic              bat2_cmp_en,
    output logic              bat_disconnect
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADR_STATUS);
    localparam logic [ADDR_W-1:0] A_MAIN   = ADDR_W'(ADR_MAIN);
    localparam logic [ADDR_W-1:0] A_BAT    = ADDR_W'(ADR_BAT);

    logic             wr_main, wr_bat, wr_stat;
    logic             to_battery, to_main;
    logic [NFLAG-1:0] flags;
    logic             reseal, clr_stamps;
    logic             entry_valid, return_valid;
    stamp_t           entry_stamp, return_stamp, cal_now;
    trip_t            main_sel, bat1_sel, bat2_sel;

    assign cal_now = {cal_year, cal_mon, cal_day, cal_hour, cal_min, cal_sec};
    assign wr_main = reg_wr && (reg_addr == A_MAIN);
    assign wr_bat  = reg_wr && (reg_addr == A_BAT);
    assign wr_stat = reg_wr && (reg_addr == A_STATUS);

    pwr_ts_supply_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .main_present (main_present),
        .to_battery   (to_battery),
        .to_main      (to_main)
    );

    pwr_ts_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_main    (wr_main),
        .wr_bat     (wr_bat),
        .wr_stat    (wr_stat),
        .wdata      (reg_wdata),
        .main_below (main_below),
        .bat1_below (bat1_below),
        .bat2_below (bat2_below),
        .to_main    (to_main),
        .main_sel   (main_sel),
        .bat1_sel   (bat1_sel),
        .bat2_sel   (bat2_sel),
        .main_en    (main_cmp_en),
        .bat1_en    (bat1_cmp_en),
        .bat2_en    (bat2_cmp_en),
        .flags      (flags),
        .reseal     (reseal),
        .clr_stamps (clr_stamps)
    );

    pwr_ts_slot #(.KEEP_FIRST(1'b1)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (to_battery),
        .clr      (clr_stamps),
        .stamp_in (cal_now),
        .valid    (entry_valid),
        .stamp    (entry_stamp)
    );

    pwr_ts_slot #(.KEEP_FIRST(1'b0)) u_return (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (to_main),
        .clr      (clr_stamps),
        .stamp_in (cal_now),
        .valid    (return_valid),
        .stamp    (return_stamp)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS)
            reg_rdata = {3'b000, return_valid, entry_valid, flags};
        else if (reg_addr == A_MAIN)
            reg_rdata = {5'b00000, main_sel};
        else if (reg_addr == A_BAT)
            reg_rdata = {1'b0, reseal, bat1_sel, bat2_sel};
        for (int i = 0; i < NFLD; i++) begin
            if (reg_addr == ADDR_W'(ADR_ENTRY + i))
                reg_rdata = entry_stamp[i*DW +: DW];
            if (reg_addr == ADDR_W'(ADR_RETURN + i))
                reg_rdata = return_stamp[i*DW +: DW];
        end
    end

    assign main_trip_code = main_sel;
    assign bat1_trip_code = bat1_sel;
    assign bat2_trip_code = bat2_sel;
    assign bat_disconnect = reseal;
endmodule

// File: rtl/pwr_ts_chk.sv
module pwr_ts_chk
    import pwr_ts_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              main_present,
    input logic              main_cmp_en,
    input logic              bat_disconnect,
    input logic [NFLAG-1:0]  flags,
    input logic              entry_valid,
    input logic              return_valid,
    input stamp_t            entry_stamp
);
    logic clr_wr, flag0_clr_wr;
    assign clr_wr       = reg_wr && (reg_addr == ADDR_W'(ADR_MAIN)) && reg_wdata[7];
    assign flag0_clr_wr = reg_wr && (reg_addr == ADDR_W'(ADR_STATUS)) && !reg_wdata[FLG_MAIN];

    assert_main_off_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_cmp_en && !flags[FLG_MAIN]) |=> !flags[FLG_MAIN]);

    assert_entry_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && !clr_wr) |=> $stable(entry_stamp));

    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (!entry_valid && !return_valid));

    assert_reseal_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_present) |=> !bat_disconnect);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLG_MAIN] && !flag0_clr_wr) |=> flags[FLG_MAIN]);

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(ADR_MAIN)) |-> (reg_rdata[7:3] == 5'd0));
endmodule

bind pwr_ts_top pwr_ts_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .main_present   (main_present),
    .main_cmp_en    (main_cmp_en),
    .bat_disconnect (bat_disconnect),
    .flags          (flags),
    .entry_valid    (entry_valid),
    .return_valid   (return_valid),
    .entry_stamp    (entry_stamp)
);

// File: tb/pwr_ts_top_tb.sv
module pwr_ts_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       main_present = 1'b1;
    logic       main_below = 1'b0, bat1_below = 1'b0, bat2_below = 1'b0;
    logic [7:0] cal_sec = '0, cal_min = '0, cal_hour = '0, cal_day = '0, cal_mon = '0, cal_year = '0;
    logic [2:0] main_trip_code, bat1_trip_code, bat2_trip_code;
    logic       main_cmp_en, bat1_cmp_en, bat2_cmp_en, bat_disconnect;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwr_ts_top #(.ADDR_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .main_present(main_present),
        .main_below(main_below), .bat1_below(bat1_below), .bat2_below(bat2_below),
        .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour), .cal_day(cal_day),
        .cal_mon(cal_mon), .cal_year(cal_year), .main_trip_code(main_trip_code),
        .main_cmp_en(main_cmp_en), .bat1_trip_code(bat1_trip_code), .bat1_cmp_en(bat1_cmp_en),
        .bat2_trip_code(bat2_trip_code), .bat2_cmp_en(bat2_cmp_en), .bat_disconnect(bat_disconnect)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_cal(input logic [7:0] base);
        cal_sec = base; cal_min = base + 8'd1; cal_hour = base + 8'd2;
        cal_day = base + 8'd3; cal_mon = base + 8'd4; cal_year = base + 8'd5;
    endtask

    task automatic supply(input logic up, input logic [7:0] base);
        @(negedge clk);
        set_cal(base);
        main_present = up;
        @(negedge clk);
        set_cal(base ^ 8'h80);
        @(negedge clk);
    endtask

    task automatic check_rec(input string req, input int adr, input int base);
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(5'(adr + i), v);
            check(req, int'(v), base == 0 ? 0 : ((base + i) & 8'hFF));
        end
    endtask

    initial begin
        #(3_000_000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(5'h00, v); check("R8 reset status", int'(v), 0);
        rd(5'h09, v); check("R1 reset main reg", int'(v), 0);
        rd(5'h0A, v); check("R3 reset bat reg", int'(v), 0);
        check("R7 reset disconnect", int'(bat_disconnect), 0);

        // R1 / R2 sweep of main codes, reserved bits 6:3 written as ones (R9)
        for (int c = 0; c < 8; c++) begin
            wr(5'h09, 8'h78 | 8'(c));
            rd(5'h09, v);
            check("R1 main code readback", int'(v), c);
            check("R1 main code pin", int'(main_trip_code), c);
            check("R2 main enable", int'(main_cmp_en), c <= 5 ? 1 : 0);
            @(negedge clk); main_below = 1'b1;
            @(negedge clk); main_below = 1'b0;
            rd(5'h00, v);
            check("R2 main flag", int'(v[0]), c <= 5 ? 1 : 0);
            wr(5'h00, 8'h00);
            rd(5'h00, v);
            check("R8 clear by zero", int'(v[2:0]), 0);
        end

        // R3 sweep of all battery code pairs, bit 7 written as one (R9)
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                wr(5'h0A, 8'h80 | 8'(a << 3) | 8'(b));
                rd(5'h0A, v);
                check("R3 bat readback", int'(v), (a << 3) | b);
                check("R3 bat1 pin", int'(bat1_trip_code), a);
                check("R3 bat2 pin", int'(bat2_trip_code), b);
                check("R3 bat1 enable", int'(bat1_cmp_en), a <= 6 ? 1 : 0);
                check("R3 bat2 enable", int'(bat2_cmp_en), b <= 6 ? 1 : 0);
                @(negedge clk); bat1_below = 1'b1; bat2_below = 1'b1;
                @(negedge clk); bat1_below = 1'b0; bat2_below = 1'b0;
                rd(5'h00, v);
                check("R3 bat flags", int'(v[2:0]), ((b <= 6 ? 1 : 0) << 2) | ((a <= 6 ? 1 : 0) << 1));
                wr(5'h00, 8'h00);
            end
        end
        wr(5'h0A, 8'h00);
        wr(5'h09, 8'h02);

        // R8 stickiness
        @(negedge clk); main_below = 1'b1;
        @(negedge clk); main_below = 1'b0;
        repeat (3) @(negedge clk);
        rd(5'h00, v); check("R8 flag stays after condition", int'(v[0]), 1);
        wr(5'h00, 8'hFF);
        rd(5'h00, v); check("R8 write one no effect", int'(v[0]), 1);
        @(negedge clk); main_below = 1'b1;
        wr(5'h00, 8'h00);
        rd(5'h00, v); check("R8 set beats clear", int'(v[0]), 1);
        main_below = 1'b0;
        wr(5'h00, 8'h00);
        rd(5'h00, v); check("R8 cleared", int'(v), 0);

        // R4 / R5 / R10 repeated supply cycles
        for (int k = 0; k < 4; k++) begin
            supply(1'b0, 8'(8'h10 + 8 * k));
            check_rec("R4 entry record first only", 16, 8'h10);
            supply(1'b1, 8'(8'h40 + 8 * k));
            check_rec("R5 return record latest", 24, 8'h40 + 8 * k);
            rd(5'h00, v); check("R4 R5 valid bits", int'(v[4:3]), 3);
        end

        // R6 clear
        wr(5'h09, 8'h82);
        rd(5'h09, v); check("R6 clear bit reads zero", int'(v), 2);
        rd(5'h00, v); check("R6 valid bits cleared", int'(v[4:3]), 0);
        check_rec("R6 entry cleared", 16, 0);
        check_rec("R6 return cleared", 24, 0);
        supply(1'b0, 8'h60);
        check_rec("R4 R10 capture after clear", 16, 8'h60);
        check_rec("R6 return still empty", 24, 0);
        supply(1'b1, 8'h70);

        // R7 shipping bit
        wr(5'h0A, 8'h40);
        rd(5'h0A, v); check("R7 reseal readback", int'(v), 8'h40);
        check("R7 disconnect asserted", int'(bat_disconnect), 1);
        supply(1'b0, 8'h20);
        check("R7 held while down", int'(bat_disconnect), 1);
        supply(1'b1, 8'h30);
        check("R7 cleared on return", int'(bat_disconnect), 0);
        rd(5'h0A, v); check("R7 bit reads zero", int'(v), 0);

        // R9 unmapped address and status reserved bits
        wr(5'h05, 8'hFF);
        rd(5'h05, v); check("R9 unmapped reads zero", int'(v), 0);
        wr(5'h00, 8'hE0);
        rd(5'h00, v); check("R9 status high bits", int'(v[7:5]), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule